// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the core of a microcoded control unit. It keeps a micro-program counter, a read-only control store computed in the RTL, and a microinstruction buffer whose contents are decoded into a vector of micro-order lines and a function-unit code. The surrounding datapath (instruction register, memory, ALU, accumulator) is outside the block. That datapath acts on the micro-orders and supplies back the current opcode and a zero status flag.

Every microinstruction is handled in two clock cycles. In the fill cycle the buffer is empty, so no micro-order is active, and the control store word at the micro-PC is loaded. In the execute cycle the buffer is decoded onto the outputs and the next micro-address is chosen. Each microinstruction carries a branch flag, a sequencing mode and an embedded control-store target. With the flag clear, the micro-PC steps by one. With the flag set, it jumps to the target, dispatches on the opcode, or jumps only when the zero flag is set.

The control store contains a reset routine, a three-step instruction fetch, one routine per defined opcode and an interrupt-initiation routine. A parameter selects how the control field is stored. In the horizontal form there is one bit per line. In the vertical form, field groups pass through small decoders. Both forms produce the same outputs. The block has no data stream, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `ucs_sequencer`

## Requirements
- R1: `rst_n` is an asynchronous, active-low reset. While it is low, `upc_o` is 0 and `morders` and `fu_code` are all zero. The first microinstruction after release sits at address 0, asserts only clear-accumulator (bit 10), and branches to fetch at address 1.
- R2: Each microinstruction takes one fill cycle followed by one execute cycle. In the fill cycle `morders` and `fu_code` are zero, and `upc_o` keeps its value across both cycles. `morders` bit layout: 0 PC to A-bus, 1 IR address to A-bus, 2 memory to D-bus, 3 function unit to D-bus, 4 memory read, 5 load IR, 6 load X, 7 load accumulator, 8 load PC, 9 increment PC, 10 clear accumulator, 11 save context, 12 interrupt acknowledge.
- R3: When the executed microinstruction's branch flag is clear, `upc_o` becomes the old value plus one at the end of its execute cycle.
- R4: When the branch flag is set with the unconditional mode, `upc_o` becomes the target field held in that same microinstruction.
- R5: The dispatch microinstruction loads the micro-PC with the start address for `ir_opcode`: opcode 0 → 4 (no-op), 1 → 5 (add), 2 → 7 (complement), 3 → 9 (branch on zero), 4 → 12 (load).
- R6: Opcodes 5, 6 and 7 dispatch to the interrupt routine at address 16, which asserts save-context (bit 11), then at 17 interrupt-acknowledge (bit 12), then returns to fetch.
- R7: The fetch routine asserts bits {0,2,4} at address 1, bits {2,5} at address 2, and bit 9 at address 3, where it dispatches.
- R8: `fu_code` is 001 (add) at addresses 5 and 6 and 101 (complement) at address 7. It is 000 everywhere else.
- R9: Each opcode routine ends by branching to fetch (address 1). The no-op routine is the single empty word at 4. The load routine is the single word at 12, asserting bits {1,2,4,7}.
- R10: At address 9 the branch is taken to 11 (asserting load-PC, bit 8) when `stat_zero` is 1. When `stat_zero` is 0 the micro-PC goes to 10, and both paths then return to fetch.
- R11: The horizontal (`VERT`=0) and vertical (`VERT`=1) encodings produce identical `morders`, `fu_code` and `upc_o` in every cycle for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | OP_W (3) | Opcode currently held in the instruction register |
| stat_zero | input | 1 | Zero status flag from the datapath |
| morders | output | NORD (13) | Decoded micro-order lines |
| fu_code | output | FU_W (3) | Function-unit operation code |
| upc_o | output | AW (5) | Current micro-address |

## Verification
A microinstruction's micro-orders and function code appear right after the rising edge that loads its word and return to zero after the next edge. That next edge is also where `upc_o` takes the new micro-address. The opcode and zero flag are only examined during the execute cycle of the microinstruction that dispatches or tests them. The bench therefore drives those inputs at the falling edge inside that execute cycle. It checks each execute cycle at the falling edge after the loading edge, and each fill cycle (zero outputs, next address) one edge later. Both encodings run side by side and are compared in every sampled cycle.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

  localparam int NORD  = 13;
  localparam int FU_W  = 3;
  localparam int UA_W  = 5;
  localparam int OP_W  = 3;

  // micro-order line positions
  localparam int O_PC_ABUS  = 0;
  localparam int O_IR_ABUS  = 1;
  localparam int O_MEM_DBUS = 2;
  localparam int O_FU_DBUS  = 3;
  localparam int O_MEM_RD   = 4;
  localparam int O_LD_IR    = 5;
  localparam int O_LD_X     = 6;
  localparam int O_LD_ACC   = 7;
  localparam int O_LD_PC    = 8;
  localparam int O_INC_PC   = 9;
  localparam int O_CLR_ACC  = 10;
  localparam int O_SAVE_CTX = 11;
  localparam int O_INT_ACK  = 12;

  localparam logic [NORD-1:0] M_NONE     = '0;
  localparam logic [NORD-1:0] M_PC_ABUS  = NORD'(1) << O_PC_ABUS;
  localparam logic [NORD-1:0] M_IR_ABUS  = NORD'(1) << O_IR_ABUS;
  localparam logic [NORD-1:0] M_MEM_DBUS = NORD'(1) << O_MEM_DBUS;
  localparam logic [NORD-1:0] M_FU_DBUS  = NORD'(1) << O_FU_DBUS;
  localparam logic [NORD-1:0] M_MEM_RD   = NORD'(1) << O_MEM_RD;
  localparam logic [NORD-1:0] M_LD_IR    = NORD'(1) << O_LD_IR;
  localparam logic [NORD-1:0] M_LD_X     = NORD'(1) << O_LD_X;
  localparam logic [NORD-1:0] M_LD_ACC   = NORD'(1) << O_LD_ACC;
  localparam logic [NORD-1:0] M_LD_PC    = NORD'(1) << O_LD_PC;
  localparam logic [NORD-1:0] M_INC_PC   = NORD'(1) << O_INC_PC;
  localparam logic [NORD-1:0] M_CLR_ACC  = NORD'(1) << O_CLR_ACC;
  localparam logic [NORD-1:0] M_SAVE_CTX = NORD'(1) << O_SAVE_CTX;
  localparam logic [NORD-1:0] M_INT_ACK  = NORD'(1) << O_INT_ACK;

  // function-unit codes
  localparam logic [FU_W-1:0] FU_NONE = 3'b000;
  localparam logic [FU_W-1:0] FU_ADD  = 3'b001;
  localparam logic [FU_W-1:0] FU_NOT  = 3'b101;

  // vertical control field: {misc, dest, dsrc, asrc}
  localparam int VA_W   = 2;
  localparam int VD_W   = 2;
  localparam int VL_W   = 3;
  localparam int VM_W   = 5;
  localparam int VCTL_W = VA_W + VD_W + VL_W + VM_W;

  // fixed control-store addresses
  localparam int RESET_VEC  = 0;
  localparam int FETCH_ADDR = 1;
  localparam int DISP_ADDR  = 3;
  localparam int R_NOP      = 4;
  localparam int R_ADD      = 5;
  localparam int R_NOT      = 7;
  localparam int R_BRZ      = 9;
  localparam int R_BRZ_TKN  = 11;
  localparam int R_LDA      = 12;
  localparam int INTR_ADDR  = 16;
  localparam int OP_LAST    = 4;

  typedef enum logic [1:0] {
    SQ_GOTO     = 2'd0,
    SQ_DISPATCH = 2'd1,
    SQ_IFZ      = 2'd2
  } seq_mode_e;

  typedef struct packed {
    logic            br;
    seq_mode_e       mode;
    logic [UA_W-1:0] target;
    logic [FU_W-1:0] fu;
    logic [NORD-1:0] ord;
  } uop_t;

  function automatic uop_t mk(logic [NORD-1:0] o, logic [FU_W-1:0] f,
                              logic b, seq_mode_e m, int t);
    uop_t u;
    u.br     = b;
    u.mode   = m;
    u.target = UA_W'(t);
    u.fu     = f;
    u.ord    = o;
    return u;
  endfunction

  // microprogram contents; unused words trap to interrupt initiation
  function automatic uop_t uop_at(int a);
    case (a)
      0:  return mk(M_CLR_ACC, FU_NONE, 1'b1, SQ_GOTO, FETCH_ADDR);
      1:  return mk(M_PC_ABUS | M_MEM_RD | M_MEM_DBUS, FU_NONE, 1'b0, SQ_GOTO, 0);
      2:  return mk(M_MEM_DBUS | M_LD_IR, FU_NONE, 1'b0, SQ_GOTO, 0);
      3:  return mk(M_INC_PC, FU_NONE, 1'b1, SQ_DISPATCH, 0);
      4:  return mk(M_NONE, FU_NONE, 1'b1, SQ_GOTO, FETCH_ADDR);
      5:  return mk(M_IR_ABUS | M_MEM_RD | M_MEM_DBUS, FU_ADD, 1'b0, SQ_GOTO, 0);
      6:  return mk(M_FU_DBUS | M_LD_ACC, FU_ADD, 1'b1, SQ_GOTO, FETCH_ADDR);
      7:  return mk(M_LD_X, FU_NOT, 1'b0, SQ_GOTO, 0);
      8:  return mk(M_FU_DBUS | M_LD_ACC, FU_NONE, 1'b1, SQ_GOTO, FETCH_ADDR);
      9:  return mk(M_NONE, FU_NONE, 1'b1, SQ_IFZ, R_BRZ_TKN);
      10: return mk(M_NONE, FU_NONE, 1'b1, SQ_GOTO, FETCH_ADDR);
      11: return mk(M_LD_PC, FU_NONE, 1'b1, SQ_GOTO, FETCH_ADDR);
      12: return mk(M_IR_ABUS | M_MEM_RD | M_MEM_DBUS | M_LD_ACC, FU_NONE,
                    1'b1, SQ_GOTO, FETCH_ADDR);
      16: return mk(M_SAVE_CTX, FU_NONE, 1'b0, SQ_GOTO, 0);
      17: return mk(M_INT_ACK, FU_NONE, 1'b1, SQ_GOTO, FETCH_ADDR);
      default: return mk(M_NONE, FU_NONE, 1'b1, SQ_GOTO, INTR_ADDR);
    endcase
  endfunction

  // opcode to routine start address
  function automatic logic [UA_W-1:0] op_start(logic [OP_W-1:0] op);
    case (op)
      3'd0:    return UA_W'(R_NOP);
      3'd1:    return UA_W'(R_ADD);
      3'd2:    return UA_W'(R_NOT);
      3'd3:    return UA_W'(R_BRZ);
      3'd4:    return UA_W'(R_LDA);
      default: return UA_W'(INTR_ADDR);
    endcase
  endfunction

  // pack horizontal orders into grouped vertical fields
  function automatic logic [VCTL_W-1:0] vencode(logic [NORD-1:0] o);
    logic [VA_W-1:0] asrc;
    logic [VD_W-1:0] dsrc;
    logic [VL_W-1:0] dst;
    logic [VM_W-1:0] misc;
    asrc = o[O_PC_ABUS] ? 2'd1 : (o[O_IR_ABUS] ? 2'd2 : 2'd0);
    dsrc = o[O_MEM_DBUS] ? 2'd1 : (o[O_FU_DBUS] ? 2'd2 : 2'd0);
    dst  = o[O_LD_IR] ? 3'd1 : o[O_LD_X] ? 3'd2 : o[O_LD_ACC] ? 3'd3 :
           o[O_LD_PC] ? 3'd4 : 3'd0;
    misc = {o[O_INT_ACK], o[O_SAVE_CTX], o[O_CLR_ACC], o[O_INC_PC], o[O_MEM_RD]};
    return {misc, dst, dsrc, asrc};
  endfunction

endpackage

// File: rtl/ucs_store.sv
module ucs_store
  import ucs_pkg::*;
#(
  parameter int AW   = UA_W,
  parameter bit VERT = 1'b0,
  localparam int CTL_W  = VERT ? VCTL_W : NORD,
  localparam int WORD_W = 1 + 2 + UA_W + FU_W + CTL_W,
  localparam int DEPTH  = 1 << AW
)(
  input  logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] word
);

  function automatic logic [WORD_W-1:0] pack_word(uop_t u);
    logic [CTL_W-1:0] c;
    if (VERT) c = CTL_W'(vencode(u.ord));
    else      c = CTL_W'(u.ord);
    return {u.br, u.mode, u.target, u.fu, c};
  endfunction

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign rom[a] = pack_word(uop_at(a));
  end

  assign word = rom[addr];

endmodule

// File: rtl/ucs_decode.sv
module ucs_decode
  import ucs_pkg::*;
#(
  parameter bit VERT = 1'b0,
  localparam int CTL_W = VERT ? VCTL_W : NORD
)(
  input  logic [CTL_W-1:0] ctl,
  output logic [NORD-1:0]  ord
);

  if (VERT) begin : g_vert
    logic [VA_W-1:0] asrc;
    logic [VD_W-1:0] dsrc;
    logic [VL_W-1:0] dst;
    logic [VM_W-1:0] misc;
    assign {misc, dst, dsrc, asrc} = ctl;

    always_comb begin
      ord = '0;
      case (asrc)
        2'd1:    ord[O_PC_ABUS] = 1'b1;
        2'd2:    ord[O_IR_ABUS] = 1'b1;
        default: ;
      endcase
      case (dsrc)
        2'd1:    ord[O_MEM_DBUS] = 1'b1;
        2'd2:    ord[O_FU_DBUS]  = 1'b1;
        default: ;
      endcase
      case (dst)
        3'd1:    ord[O_LD_IR]  = 1'b1;
        3'd2:    ord[O_LD_X]   = 1'b1;
        3'd3:    ord[O_LD_ACC] = 1'b1;
        3'd4:    ord[O_LD_PC]  = 1'b1;
        default: ;
      endcase
      ord[O_MEM_RD]   = misc[0];
      ord[O_INC_PC]   = misc[1];
      ord[O_CLR_ACC]  = misc[2];
      ord[O_SAVE_CTX] = misc[3];
      ord[O_INT_ACK]  = misc[4];
    end
  end else begin : g_horiz
    assign ord = ctl;
  end

endmodule

// File: rtl/ucs_next.sv
module ucs_next
  import ucs_pkg::*;
#(
  parameter int AW = UA_W
)(
  input  logic [AW-1:0]   upc,
  input  logic            br,
  input  seq_mode_e       mode,
  input  logic [UA_W-1:0] target,
  input  logic [OP_W-1:0] opcode,
  input  logic            zero,
  output logic [AW-1:0]   nxt
);

  logic [AW-1:0] seq_addr;
  logic [AW-1:0] tgt_addr;
  logic [AW-1:0] disp_addr;

  assign seq_addr  = upc + AW'(1);
  assign tgt_addr  = AW'(target);
  assign disp_addr = AW'(op_start(opcode));

  always_comb begin
    nxt = seq_addr;
    if (br) begin
      case (mode)
        SQ_GOTO:     nxt = tgt_addr;
        SQ_DISPATCH: nxt = disp_addr;
        SQ_IFZ:      nxt = zero ? tgt_addr : seq_addr;
        default:     nxt = seq_addr;
      endcase
    end
  end

endmodule

// File: rtl/ucs_sequencer.sv
module ucs_sequencer
  import ucs_pkg::*;
#(
  parameter int AW   = UA_W,
  parameter bit VERT = 1'b0
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] ir_opcode,
  input  logic            stat_zero,
  output logic [NORD-1:0] morders,
  output logic [FU_W-1:0] fu_code,
  output logic [AW-1:0]   upc_o
);

  localparam int CTL_W  = VERT ? VCTL_W : NORD;
  localparam int WORD_W = 1 + 2 + UA_W + FU_W + CTL_W;
  localparam int FU_LSB = CTL_W;
  localparam int TG_LSB = FU_LSB + FU_W;
  localparam int MD_LSB = TG_LSB + UA_W;

  typedef enum logic {PH_FILL = 1'b0, PH_EXEC = 1'b1} phase_e;

  phase_e            ph_q;
  logic [AW-1:0]     upc_q;
  logic [AW-1:0]     upc_nxt;
  logic [WORD_W-1:0] store_word;
  logic [WORD_W-1:0] ubuf_q;

  logic              buf_br;
  seq_mode_e         buf_mode;
  logic [UA_W-1:0]   buf_target;
  logic [CTL_W-1:0]  buf_ctl;

  assign buf_br     = ubuf_q[WORD_W-1];
  assign buf_mode   = seq_mode_e'(ubuf_q[MD_LSB +: 2]);
  assign buf_target = ubuf_q[TG_LSB +: UA_W];
  assign buf_ctl    = ubuf_q[CTL_W-1:0];

  ucs_store #(.AW(AW), .VERT(VERT)) u_store (
    .addr (upc_q),
    .word (store_word)
  );

  ucs_next #(.AW(AW)) u_next (
    .upc    (upc_q),
    .br     (buf_br),
    .mode   (buf_mode),
    .target (buf_target),
    .opcode (ir_opcode),
    .zero   (stat_zero),
    .nxt    (upc_nxt)
  );

  ucs_decode #(.VERT(VERT)) u_decode (
    .ctl (buf_ctl),
    .ord (morders)
  );

  // fill: load store word into cleared buffer; exec: advance and clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_FILL;
      upc_q  <= AW'(RESET_VEC);
      ubuf_q <= '0;
    end else if (ph_q == PH_FILL) begin
      ubuf_q <= store_word;
      ph_q   <= PH_EXEC;
    end else begin
      ubuf_q <= '0;
      upc_q  <= upc_nxt;
      ph_q   <= PH_FILL;
    end
  end

  assign fu_code = ubuf_q[FU_LSB +: FU_W];
  assign upc_o   = upc_q;

  // R2: buffer is emptied after every execute cycle
  a_r2_clear_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EXEC) |=> (morders == '0 && fu_code == '0));

  // R2: micro-address holds through the fill cycle
  a_r2_hold_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FILL) |=> $stable(upc_o));

  // R3: non-branching word steps the micro-PC
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EXEC && !buf_br) |=> (upc_o == $past(upc_o) + AW'(1)));

  // R4: unconditional branch takes the embedded target
  a_r4_goto: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EXEC && buf_br && buf_mode == SQ_GOTO)
      |=> (upc_o == AW'($past(buf_target))));

  // R6: undefined opcode lands on interrupt initiation
  a_r6_undef_op: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EXEC && buf_br && buf_mode == SQ_DISPATCH && int'(ir_opcode) > OP_LAST)
      |=> (upc_o == AW'(INTR_ADDR)));

  // R10: zero flag set makes the conditional branch taken
  a_r10_zero_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EXEC && buf_br && buf_mode == SQ_IFZ && stat_zero)
      |=> (upc_o == AW'($past(buf_target))));

endmodule

// File: tb/test_ucs_sequencer.sv
`timescale 1ns/1ps
module test_ucs_sequencer;

  localparam logic [12:0] O_NO  = 13'h0000;
  localparam logic [12:0] O_PCA = 13'h0001;
  localparam logic [12:0] O_IRA = 13'h0002;
  localparam logic [12:0] O_MDB = 13'h0004;
  localparam logic [12:0] O_FDB = 13'h0008;
  localparam logic [12:0] O_MRD = 13'h0010;
  localparam logic [12:0] O_LIR = 13'h0020;
  localparam logic [12:0] O_LX  = 13'h0040;
  localparam logic [12:0] O_LAC = 13'h0080;
  localparam logic [12:0] O_LPC = 13'h0100;
  localparam logic [12:0] O_INC = 13'h0200;
  localparam logic [12:0] O_CLR = 13'h0400;
  localparam logic [12:0] O_SAV = 13'h0800;
  localparam logic [12:0] O_ACK = 13'h1000;

  localparam logic [12:0] F1 = O_PCA | O_MRD | O_MDB;
  localparam logic [12:0] F2 = O_MDB | O_LIR;

  localparam int NV = 40;
  // row: {upc[5], opcode[3], zero[1], orders[13], fu[3]}
  localparam logic [24:0] VEC [NV] = '{
    {5'd0,  3'd1, 1'b0, O_CLR, 3'd0},
    {5'd1,  3'd1, 1'b0, F1, 3'd0},
    {5'd2,  3'd1, 1'b0, F2, 3'd0},
    {5'd3,  3'd1, 1'b0, O_INC, 3'd0},
    {5'd5,  3'd1, 1'b0, O_IRA | O_MRD | O_MDB, 3'b001},
    {5'd6,  3'd1, 1'b0, O_FDB | O_LAC, 3'b001},
    {5'd1,  3'd2, 1'b0, F1, 3'd0},
    {5'd2,  3'd2, 1'b0, F2, 3'd0},
    {5'd3,  3'd2, 1'b0, O_INC, 3'd0},
    {5'd7,  3'd2, 1'b0, O_LX, 3'b101},
    {5'd8,  3'd2, 1'b0, O_FDB | O_LAC, 3'd0},
    {5'd1,  3'd0, 1'b0, F1, 3'd0},
    {5'd2,  3'd0, 1'b0, F2, 3'd0},
    {5'd3,  3'd0, 1'b0, O_INC, 3'd0},
    {5'd4,  3'd0, 1'b0, O_NO, 3'd0},
    {5'd1,  3'd3, 1'b1, F1, 3'd0},
    {5'd2,  3'd3, 1'b1, F2, 3'd0},
    {5'd3,  3'd3, 1'b1, O_INC, 3'd0},
    {5'd9,  3'd3, 1'b1, O_NO, 3'd0},
    {5'd11, 3'd3, 1'b0, O_LPC, 3'd0},
    {5'd1,  3'd3, 1'b0, F1, 3'd0},
    {5'd2,  3'd3, 1'b0, F2, 3'd0},
    {5'd3,  3'd3, 1'b0, O_INC, 3'd0},
    {5'd9,  3'd3, 1'b0, O_NO, 3'd0},
    {5'd10, 3'd3, 1'b0, O_NO, 3'd0},
    {5'd1,  3'd4, 1'b0, F1, 3'd0},
    {5'd2,  3'd4, 1'b0, F2, 3'd0},
    {5'd3,  3'd4, 1'b0, O_INC, 3'd0},
    {5'd12, 3'd4, 1'b0, O_IRA | O_MRD | O_MDB | O_LAC, 3'd0},
    {5'd1,  3'd6, 1'b0, F1, 3'd0},
    {5'd2,  3'd6, 1'b0, F2, 3'd0},
    {5'd3,  3'd6, 1'b0, O_INC, 3'd0},
    {5'd16, 3'd6, 1'b0, O_SAV, 3'd0},
    {5'd17, 3'd6, 1'b0, O_ACK, 3'd0},
    {5'd1,  3'd5, 1'b0, F1, 3'd0},
    {5'd2,  3'd5, 1'b0, F2, 3'd0},
    {5'd3,  3'd5, 1'b0, O_INC, 3'd0},
    {5'd16, 3'd5, 1'b0, O_SAV, 3'd0},
    {5'd17, 3'd5, 1'b0, O_ACK, 3'd0},
    {5'd1,  3'd0, 1'b0, F1, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ir_op = 3'd0;
  logic        zf = 1'b0;
  logic [12:0] ord_h, ord_v;
  logic [2:0]  fu_h, fu_v;
  logic [4:0]  upc_h, upc_v;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ucs_sequencer #(.AW(5), .VERT(1'b0)) i_ucs_sequencer (
    .clk (clk), .rst_n (rst_n), .ir_opcode (ir_op), .stat_zero (zf),
    .morders (ord_h), .fu_code (fu_h), .upc_o (upc_h)
  );

  ucs_sequencer #(.AW(5), .VERT(1'b1)) i_ucs_sequencer_v (
    .clk (clk), .rst_n (rst_n), .ir_opcode (ir_op), .stat_zero (zf),
    .morders (ord_v), .fu_code (fu_v), .upc_o (upc_v)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_same();
    check("R11", "encodings agree on orders", int'(ord_v), int'(ord_h));
    check("R11", "encodings agree on fu", int'(fu_v), int'(fu_h));
    check("R11", "encodings agree on upc", int'(upc_v), int'(upc_h));
  endtask

  function automatic string tag_of(int u);
    case (u)
      0:               return "R1";
      1, 2, 3:         return "R7";
      5, 6, 7, 8:      return "R8";
      9, 10, 11:       return "R10";
      16, 17:          return "R6";
      default:         return "R9";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "upc in reset", int'(upc_h), 0);
    check("R1", "orders in reset", int'(ord_h), 0);
    check("R1", "fu in reset", int'(fu_h), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int eu, eo, ef, nu;
      eu = int'(VEC[i][24:20]);
      eo = int'(VEC[i][15:3]);
      ef = int'(VEC[i][2:0]);
      @(posedge clk);
      @(negedge clk);
      check(tag_of(eu), "exec upc", int'(upc_h), eu);
      check(tag_of(eu), "exec orders", int'(ord_h), eo);
      check("R8", "fu code", int'(fu_h), ef);
      check_same();
      ir_op = VEC[i][19:17];
      zf    = VEC[i][16];
      @(posedge clk);
      @(negedge clk);
      check("R2", "fill orders zero", int'(ord_h), 0);
      check("R2", "fill fu zero", int'(fu_h), 0);
      check_same();
      if (i < NV - 1) begin
        nu = int'(VEC[i+1][24:20]);
        if (eu == 3)
          check("R5", "dispatch target", int'(upc_h), nu);
        else if (nu == 1 && eu != 0)
          check("R9", "return to fetch", int'(upc_h), nu);
        else if (nu == eu + 1)
          check("R3", "sequential step", int'(upc_h), nu);
        else
          check("R4", "branch target", int'(upc_h), nu);
      end
    end

    // asynchronous reset in the middle of a run
    rst_n = 1'b0;
    #1;
    check("R1", "upc after async reset", int'(upc_h), 0);
    check("R1", "orders after async reset", int'(ord_h), 0);
    @(negedge clk);
    rst_n = 1'b1;
    ir_op = 3'd7;
    @(posedge clk);
    @(negedge clk);
    check("R1", "reset routine orders", int'(ord_h), int'(O_CLR));
    check("R1", "reset routine address", int'(upc_h), 0);

    // undefined opcode 7 reaches interrupt initiation
    repeat (8) @(posedge clk);
    @(negedge clk);
    check("R6", "opcode 7 upc", int'(upc_h), 16);
    check("R6", "opcode 7 orders", int'(ord_h), int'(O_SAV));
    check_same();

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule